// File: doc/BRIEF.md
# SECDED Memory Protection Wrapper with Patrol Scrub

This block sits between a single requester and a synchronous RAM whose words are 72 bits wide: 64 data bits plus 8 check bits. Every write is encoded with an extended Hamming code. Every read is decoded as the word leaves the RAM. A single flipped bit is repaired in the same cycle the data is returned. Two flipped bits are flagged as uncorrectable.

Writes that cover only some bytes become a two-cycle read, merge and write sequence, so the stored word always carries valid check bits. When the requester is quiet and scrubbing is enabled, the block walks the RAM one word at a time. It rewrites any word holding a correctable error, so that single upsets cannot pile up into double ones.

Two controls set the policy. Correction can be switched off, leaving the block in detect-only mode. Error events can either only update the counters or also raise an interrupt pulse. Each error class has a saturating counter and holds the address of its most recent event.

Top module: `ecc_mem_guard`

## Requirements
- R1: A write with all eight byte enables set is accepted in one cycle and issues exactly one RAM write of all 72 bits to the request address, with no RAM read.
- R2: A write with any byte enable clear issues a RAM read of the addressed word in its acceptance cycle and a RAM write to the same address in the next cycle. Enabled bytes take the new data. The other bytes keep the stored content, corrected when correction is on.
- R3: A read request issues one RAM read in its acceptance cycle. `rsp_valid_o` is high for exactly the following cycle and carries all 64 data bits.
- R4: With `corr_en_i` high, a stored word with any one bit flipped returns the original data with `rsp_ce_o`=1 and `rsp_ue_o`=0. A read does not rewrite the stored word.
- R5: A stored word with two bits flipped returns `rsp_ue_o`=1 and `rsp_ce_o`=0, and the data as stored, without correction. Data bit j lives in the j-th codeword position, counting upward from bit 1, that is not a power of two. So codeword bit 10 holds data bit 5 and codeword bit 50 holds data bit 43.
- R6: With `corr_en_i` low, a single flipped bit is still flagged with `rsp_ce_o`=1, but the data is returned raw. Under the same layout, flipping codeword bit 9 flips data bit 4.
- R7: With `scrub_en_i` high and no request pending, the block reads successive addresses from 0 to DEPTH-1 and then wraps to 0. It writes back the corrected word whenever a single error is found and correction is on.
- R8: `req_ready_o` is high only when no access is in progress. A request that is presented then wins over starting a scrub access, and a request that arrives during a scrub waits until the scrub completes.
- R9: The correctable and uncorrectable counters each count events from reads, merges and scrubs, and hold at all ones. Each class keeps the address of its most recent event.
- R10: `irq_o` pulses high for one cycle, in the cycle after an error event, only when `irq_en_i` is high.
- R11: After reset, the counters and the stored addresses are zero, `irq_o` and `rsp_valid_o` are low, and `req_ready_o` is high.
- R12: A RAM read and a RAM write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_be_i | input | 8 | Byte enables for writes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| rsp_ce_o | output | 1 | Response had a single-bit error |
| rsp_ue_o | output | 1 | Response had an uncorrectable error |
| corr_en_i | input | 1 | Enable correction (0 = detect only) |
| scrub_en_i | input | 1 | Enable idle-time patrol scrubbing |
| irq_en_i | input | 1 | Raise interrupt on error events |
| irq_o | output | 1 | Error interrupt pulse |
| ce_cnt_o | output | CNT_W | Saturating correctable-error count |
| ue_cnt_o | output | CNT_W | Saturating uncorrectable-error count |
| ce_addr_o | output | AW | Address of last correctable error |
| ue_addr_o | output | AW | Address of last uncorrectable error |
| mem_re_o | output | 1 | RAM read strobe |
| mem_we_o | output | 1 | RAM write strobe |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | 72 | RAM write codeword |
| mem_rdata_i | input | 72 | RAM read codeword, one cycle after the read strobe |

## Verification
On every cycle, the bound checks cover the RAM-side shape of each transaction: the single write for a full write, the read-then-write pair at one address for a partial write, a response exactly one cycle after a read is accepted, request priority over the scrubber, exclusive read and write strobes, counters that never go backwards, and interrupts only while enabled. Whether the data is right cannot be seen at that level. The bench scenarios flip chosen codeword bits in the RAM model to show correction, detect-only raw data, double-error data, byte merging over a corrupted word, scrub repair across the wrap point, and counter saturation.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CODE_W = 72;
  localparam int unsigned SYN_W  = 7;
  localparam int unsigned BYTES  = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE, ST_SCRUB} ctl_state_e;

  // position 0 holds overall parity, powers of two hold Hamming check bits
  function automatic logic is_check_pos(int p);
    return (p == 0) || ((p & (p - 1)) == 0);
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    logic [CODE_W-1:0] cw;
    logic [SYN_W-1:0]  syn;
    int                k;
    cw  = '0;
    syn = '0;
    k   = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[p] = data_i[k];
        k++;
      end
    end
    for (int p = 1; p < CODE_W; p++) begin
      if (cw[p]) syn ^= SYN_W'(p);
    end
    for (int b = 0; b < SYN_W; b++) cw[1 << b] = syn[b];
    cw[0]  = ^cw[CODE_W-1:1];
    code_o = cw;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              corr_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  always_comb begin
    logic [SYN_W-1:0]  syn;
    logic [CODE_W-1:0] fixed;
    logic              par, sgl;
    int                k;
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (code_i[p]) syn ^= SYN_W'(p);
    end
    par = ^code_i;
    // odd parity with syndrome inside the word: one flipped bit at position syn
    sgl      = par && (syn < SYN_W'(CODE_W));
    double_o = (!par && (syn != '0)) || (par && (syn >= SYN_W'(CODE_W)));
    single_o = sgl;
    fixed    = code_i;
    for (int p = 0; p < CODE_W; p++) begin
      if (sgl && corr_en_i && (syn == SYN_W'(p))) fixed[p] = ~code_i[p];
    end
    data_o = '0;
    k      = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        data_o[k] = fixed[p];
        k++;
      end
    end
  end
endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [AW-1:0]    addr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [AW-1:0]    addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      addr_o <= '0;
    end else if (evt_i) begin
      addr_o <= addr_i;
      if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard
  import ecc_pkg::*;
#(
  parameter  int unsigned DEPTH = 1024,
  parameter  int unsigned CNT_W = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [BYTES-1:0]  req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_ce_o,
  output logic              rsp_ue_o,
  input  logic              corr_en_i,
  input  logic              scrub_en_i,
  input  logic              irq_en_i,
  output logic              irq_o,
  output logic [CNT_W-1:0]  ce_cnt_o,
  output logic [CNT_W-1:0]  ue_cnt_o,
  output logic [AW-1:0]     ce_addr_o,
  output logic [AW-1:0]     ue_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [CODE_W-1:0] mem_wdata_o,
  input  logic [CODE_W-1:0] mem_rdata_i
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  ctl_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, scrub_q, evt_addr;
  logic [DATA_W-1:0] wdata_q, dec_data, merged, enc_in;
  logic [BYTES-1:0]  be_q;
  logic              dec_single, dec_double, ce_evt, ue_evt;
  logic              accept, full_wr, scrub_adv;

  secded_dec u_dec (
    .code_i   (mem_rdata_i),
    .corr_en_i(corr_en_i),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  secded_enc u_enc (
    .data_i(enc_in),
    .code_o(mem_wdata_o)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign full_wr     = req_we_i && (req_be_i == '1);

  always_comb begin
    state_d     = state_q;
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    enc_in      = dec_data;
    rsp_valid_o = 1'b0;
    ce_evt      = 1'b0;
    ue_evt      = 1'b0;
    evt_addr    = addr_q;
    scrub_adv   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        enc_in = req_wdata_i;
        if (accept) begin
          mem_addr_o = req_addr_i;
          if (full_wr) begin
            mem_we_o = 1'b1;
          end else begin
            mem_re_o = 1'b1;
            state_d  = req_we_i ? ST_MERGE : ST_READ;
          end
        end else if (scrub_en_i) begin
          mem_addr_o = scrub_q;
          mem_re_o   = 1'b1;
          state_d    = ST_SCRUB;
        end
      end
      ST_READ: begin
        rsp_valid_o = 1'b1;
        ce_evt      = dec_single;
        ue_evt      = dec_double;
        state_d     = ST_IDLE;
      end
      ST_MERGE: begin
        enc_in   = merged;
        mem_we_o = 1'b1;
        ce_evt   = dec_single;
        ue_evt   = dec_double;
        state_d  = ST_IDLE;
      end
      ST_SCRUB: begin
        mem_addr_o = scrub_q;
        evt_addr   = scrub_q;
        mem_we_o   = dec_single && corr_en_i;
        ce_evt     = dec_single;
        ue_evt     = dec_double;
        scrub_adv  = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rsp_rdata_o = dec_data;
  assign rsp_ce_o    = rsp_valid_o && dec_single;
  assign rsp_ue_o    = rsp_valid_o && dec_double;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      scrub_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_o   <= irq_en_i && (ce_evt || ue_evt);
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (scrub_adv) scrub_q <= (scrub_q == LAST_ADDR) ? '0 : scrub_q + 1'b1;
    end
  end

  err_log #(.CNT_W(CNT_W), .AW(AW)) u_ce_log (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (ce_evt),
    .addr_i(evt_addr),
    .cnt_o (ce_cnt_o),
    .addr_o(ce_addr_o)
  );

  err_log #(.CNT_W(CNT_W), .AW(AW)) u_ue_log (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (ue_evt),
    .addr_i(evt_addr),
    .cnt_o (ue_cnt_o),
    .addr_o(ue_addr_o)
  );
endmodule

// File: rtl/ecc_mem_guard_chk.sv
module ecc_mem_guard_chk #(
  parameter int unsigned AW    = 10,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_we_i,
  input logic [AW-1:0]    req_addr_i,
  input logic [7:0]       req_be_i,
  input logic             rsp_valid_o,
  input logic             irq_en_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] ce_cnt_o,
  input logic [CNT_W-1:0] ue_cnt_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  // R1
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && req_be_i == 8'hFF) |-> (mem_we_o && !mem_re_o && mem_addr_o == req_addr_i));

  // R2
  rmw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && req_be_i != 8'hFF) |-> (mem_re_o && !mem_we_o));

  // R2
  rmw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && req_be_i != 8'hFF) |=> (mem_we_o && mem_addr_o == $past(req_addr_i)));

  // R3
  read_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_we_i) |=> rsp_valid_o);

  // R8
  req_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> (mem_addr_o == req_addr_i && (mem_re_o || mem_we_o)));

  // R9
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_cnt_o >= $past(ce_cnt_o)) && (ue_cnt_o >= $past(ue_cnt_o)));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));

  // R12
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
endmodule

bind ecc_mem_guard ecc_mem_guard_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_we_i   (req_we_i),
  .req_addr_i (req_addr_i),
  .req_be_i   (req_be_i),
  .rsp_valid_o(rsp_valid_o),
  .irq_en_i   (irq_en_i),
  .irq_o      (irq_o),
  .ce_cnt_o   (ce_cnt_o),
  .ue_cnt_o   (ue_cnt_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/ecc_mem_guard_bench.sv
`timescale 1ns/1ps
module ecc_mem_guard_bench;
  localparam int DEPTH = 12;
  localparam int CNT_W = 3;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [7:0]        req_be = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid, rsp_ce, rsp_ue, irq;
  logic [63:0]       rsp_rdata;
  logic              corr_en = 1'b1, scrub_en = 1'b0, irq_en = 1'b0;
  logic [CNT_W-1:0]  ce_cnt, ue_cnt;
  logic [AW-1:0]     ce_addr, ue_addr, mem_addr;
  logic              mem_re, mem_we;
  logic [71:0]       mem_wdata, mem_rdata;

  ecc_mem_guard #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ecc_mem_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_ce_o(rsp_ce), .rsp_ue_o(rsp_ue),
    .corr_en_i(corr_en), .scrub_en_i(scrub_en), .irq_en_i(irq_en), .irq_o(irq),
    .ce_cnt_o(ce_cnt), .ue_cnt_o(ue_cnt), .ce_addr_o(ce_addr), .ue_addr_o(ue_addr),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // RAM model with bit-flip injection port
  logic [71:0]   ram [16];
  logic [71:0]   ram_q = '0;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0]   inj_mask = '0;
  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (inj_en) ram[inj_addr] <= ram[inj_addr] ^ inj_mask;
    if (mem_re) ram_q <= ram[mem_addr];
  end
  assign mem_rdata = ram_q;

  int checks = 0, fails = 0, irq_seen = 0, re_seen = 0;
  bit done = 1'b0, oob_seen = 1'b0;

  typedef struct {logic [63:0] d; logic ce; logic ue; string tag;} exp_t;
  exp_t exp_q[$];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      if (mem_re) re_seen++;
      if ((mem_re || mem_we) && mem_addr >= AW'(DEPTH)) oob_seen = 1'b1;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected response", rsp_rdata, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e.d && rsp_ce == e.ce && rsp_ue == e.ue, e.tag,
              {rsp_rdata[61:0], rsp_ce, rsp_ue}, {e.d[61:0], e.ce, e.ue});
        end
      end
    end
  end

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [63:0] d, input logic ce, input logic ue, input string tag);
    exp_t e;
    e.d = d; e.ce = ce; e.ue = ue; e.tag = tag;
    exp_q.push_back(e);
    issue(1'b0, a, '0, '0);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [71:0] bitm(input int p);
    return 72'd1 << p;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all watchdog act=%0d exp=%0d", checks, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int re0;
    logic [63:0] a_word, m_word, d3, d4, pat;
    a_word = 64'h0123_4567_89AB_CDEF;
    m_word = 64'h0123_4567_1111_2222;
    d3     = 64'h5555_AAAA_0F0F_F0F0;
    d4     = 64'h8765_4321_FEDC_BA98;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk(req_ready && !rsp_valid && !irq, "R11 ready/rsp/irq", {req_ready, rsp_valid, irq}, 3'b100);
    chk(ce_cnt == 0 && ue_cnt == 0 && ce_addr == 0 && ue_addr == 0, "R11 logs",
        {ce_cnt, ue_cnt, ce_addr, ue_addr}, '0);

    // R1 full write: no RAM read
    re0 = re_seen;
    issue(1'b1, 4'd1, a_word, 8'hFF);
    chk(re_seen == re0, "R1 full write read count", 64'(re_seen - re0), 0);
    rd(4'd1, a_word, 1'b0, 1'b0, "R3 clean read");

    // R2 partial write: one RAM read, merge low four bytes
    re0 = re_seen;
    issue(1'b1, 4'd1, 64'hDEAD_BEEF_1111_2222, 8'h0F);
    idle(1);
    chk(re_seen == re0 + 1, "R2 rmw read count", 64'(re_seen - re0), 1);
    rd(4'd1, m_word, 1'b0, 1'b0, "R2 merged data");

    // R4 single error corrected, irq disabled
    inject(4'd1, bitm(37));
    rd(4'd1, m_word, 1'b1, 1'b0, "R4 corrected read");
    rd(4'd1, m_word, 1'b1, 1'b0, "R4 read leaves word unrepaired");
    idle(2);
    chk(ce_cnt == 2 && ce_addr == 1, "R9 ce log", {ce_cnt, ce_addr}, {3'd2, 4'd1});
    chk(irq_seen == 0, "R10 no irq when disabled", 64'(irq_seen), 0);

    // R5 double error, irq enabled
    issue(1'b1, 4'd2, 64'hCAFE_F00D_1234_5678, 8'hFF);
    inject(4'd2, bitm(10) | bitm(50));
    irq_en = 1'b1;
    rd(4'd2, 64'hCAFE_F00D_1234_5678 ^ (64'd1 << 5) ^ (64'd1 << 43), 1'b0, 1'b1, "R5 double detect");
    idle(2);
    irq_en = 1'b0;
    chk(irq_seen == 1, "R10 irq pulse", 64'(irq_seen), 1);
    chk(ue_cnt == 1 && ue_addr == 2, "R9 ue log", {ue_cnt, ue_addr}, {3'd1, 4'd2});

    // R9 saturation
    for (int i = 0; i < 8; i++)
      rd(4'd2, 64'hCAFE_F00D_1234_5678 ^ (64'd1 << 5) ^ (64'd1 << 43), 1'b0, 1'b1, "R5 repeat double");
    idle(2);
    chk(ue_cnt == 3'd7, "R9 ue saturates", 64'(ue_cnt), 7);
    chk(ce_cnt == 3'd2, "R9 ce untouched", 64'(ce_cnt), 2);

    // R6 detect-only
    issue(1'b1, 4'd3, d3, 8'hFF);
    inject(4'd3, bitm(9));
    corr_en = 1'b0;
    rd(4'd3, d3 ^ (64'd1 << 4), 1'b1, 1'b0, "R6 raw data in detect-only");
    idle(1);
    corr_en = 1'b1;
    rd(4'd3, d3, 1'b1, 1'b0, "R4 corrected after re-enable");

    // R2 merge over a corrupted word: codeword bit 70 = data bit 62
    issue(1'b1, 4'd4, d4, 8'hFF);
    inject(4'd4, bitm(70));
    issue(1'b1, 4'd4, 64'h0000_0000_0000_005A, 8'h01);
    rd(4'd4, {d4[63:8], 8'h5A}, 1'b0, 1'b0, "R2 merge repaired word");
    idle(2);
    chk(ce_cnt == 3'd5 && ce_addr == 4, "R9 rmw ce log", {ce_cnt, ce_addr}, {3'd5, 4'd4});

    // R7 scrub repair and wrap; R8 request during scrub
    for (int a = 0; a < DEPTH; a++) begin
      pat = {16'(a), 48'h00AB_CD00_1357};
      issue(1'b1, AW'(a), pat, 8'hFF);
    end
    ce_addr_hold: begin end
    inject(4'd5, bitm(20));
    scrub_en = 1'b1;
    idle(60);
    rd(4'd7, {16'd7, 48'h00AB_CD00_1357}, 1'b0, 1'b0, "R8 read during scrub");
    inject(4'd0, bitm(3));
    idle(60);
    scrub_en = 1'b0;
    idle(3);
    chk(ce_cnt == 3'd7 && ce_addr == 0, "R7 scrub events logged", {ce_cnt, ce_addr}, {3'd7, 4'd0});
    rd(4'd5, {16'd5, 48'h00AB_CD00_1357}, 1'b0, 1'b0, "R7 scrub repaired addr 5");
    rd(4'd0, {16'd0, 48'h00AB_CD00_1357}, 1'b0, 1'b0, "R7 scrub wrapped and repaired addr 0");
    idle(3);
    chk(!oob_seen, "R7 scrub stays below DEPTH", 64'(oob_seen), 0);
    chk(exp_q.size() == 0, "R3 all responses seen", 64'(exp_q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule